// File: doc/BRIEF.md
# SQE Heartbeat Pulse Generator

This block produces the 10Base-T heartbeat. When a transmission ends, which is the moment the transmit enable drops from high to low, it waits a fixed number of clock cycles. It then raises the collision output for a fixed number of cycles. The MAC sees that pulse as proof that its collision path is alive. The real collision indication from the line receiver is merged into the same output, so the MAC watches a single collision wire.

A one-bit management control, the inhibit bit, switches the heartbeat off. The heartbeat is also suppressed automatically while the port runs in full-duplex mode or in repeater mode. That automatic suppression is kept apart from the inhibit bit, so the bit always reads back the last value software wrote. Software writes the bit through a simple parallel strobe and data pair and reads it on a dedicated output. Both timing windows are parameters in clock cycles. The defaults of 250 cycles each give 1 µs at a 250 MHz clock.

Top module: `sqe_heartbeat`

## Requirements
- R1: While reset is held and in the first cycle after it, `col_out` equals `col_in` and `inh_rdata` reads 0, so the heartbeat is enabled out of reset.
- R2: After `tx_en` goes from 1 to 0, with the heartbeat enabled, the pulse first appears on `col_out` exactly DELAY_CYC cycles after the first clock edge that samples `tx_en` low.
- R3: The pulse stays high for exactly WIDTH_CYC consecutive cycles and then drops.
- R4: While the inhibit bit reads 1, `col_out` equals `col_in` at all times.
- R5: While `full_duplex` is 1, `col_out` equals `col_in`, whatever the inhibit bit holds.
- R6: While `repeater_mode` is 1, `col_out` equals `col_in`, whatever the inhibit bit holds.
- R7: A write (`inh_we`=1 at a clock edge) makes `inh_rdata` equal `inh_wdata` from the next cycle onward. The value stays unchanged by `full_duplex` or `repeater_mode`.
- R8: If `tx_en` returns to 1 while a pulse is pending or active, that pulse is cancelled and no heartbeat cycle follows.
- R9: `col_out` is the OR of `col_in` and the heartbeat pulse.
- R10: No pulse is produced unless `tx_en` has made a 1-to-0 transition. This holds when `tx_en` stays low from reset and when it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| col_in | input | 1 | Real collision indication from the line side |
| full_duplex | input | 1 | 1 = port in full-duplex mode (heartbeat suppressed) |
| repeater_mode | input | 1 | 1 = port in repeater mode (heartbeat suppressed) |
| inh_we | input | 1 | Write strobe for the inhibit bit |
| inh_wdata | input | 1 | Value written to the inhibit bit (1 = heartbeat off) |
| inh_rdata | output | 1 | Read-back of the inhibit bit |
| col_out | output | 1 | Merged collision output to the MAC |

## Verification
A wrong sequencer state or count shows at `col_out` as a heartbeat that starts early or late, runs short or long, or appears after an aborted frame. Each of these becomes visible within DELAY_CYC+WIDTH_CYC cycles of the falling edge. A stale edge register shows up as a missing pulse, or as a pulse with no falling edge, in the same window. A corrupted inhibit bit shows on `inh_rdata` in the cycle after the write. The bench compares a behavioural model against `col_out` and `inh_rdata` on every clock, so the first wrong cycle is caught.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_FIRE = 2'd2
    } sq_state_e;
endpackage

// File: rtl/sqe_fall_det.sv
module sqe_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } fd_regs_t;

    fd_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = tx_en_i;
        fall_o   = r_q.prev && !tx_en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/sqe_inhibit_reg.sv
module sqe_inhibit_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic wdata_i,
    output logic inh_o
);
    typedef struct packed {
        logic inh;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) r_d.inh = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign inh_o = r_q.inh;

    AST_RDBACK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (inh_o == $past(wdata_i))); // R7
    AST_RDBACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(inh_o)); // R7
endmodule

// File: rtl/sqe_pulse_seq.sv
module sqe_pulse_seq
    import sqe_pkg::*;
#(
    parameter int DELAY_CYC = 250,
    parameter int WIDTH_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic tx_en_i,
    input  logic allow_i,
    output logic pulse_o
);
    localparam int MAXC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] DLY_LOAD = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] WID_LOAD = CW'(WIDTH_CYC - 1);

    typedef struct packed {
        sq_state_e     st;
        logic [CW-1:0] cnt;
    } ps_regs_t;

    ps_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (fall_i && allow_i) begin
                    r_d.st  = SQ_WAIT;
                    r_d.cnt = DLY_LOAD;
                end
            end
            SQ_WAIT: begin
                if (tx_en_i || !allow_i) begin
                    r_d.st = SQ_IDLE;
                end else if (r_q.cnt == '0) begin
                    r_d.st  = SQ_FIRE;
                    r_d.cnt = WID_LOAD;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SQ_FIRE: begin
                if (tx_en_i || !allow_i || r_q.cnt == '0) begin
                    r_d.st = SQ_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= SQ_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse_o = (r_q.st == SQ_FIRE);

    AST_ARM_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_IDLE) && !fall_i |=> (r_q.st == SQ_IDLE)); // R10
    AST_TX_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_i |=> !pulse_o); // R8
    AST_FIRE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> !tx_en_i); // R2
endmodule

// File: rtl/sqe_heartbeat.sv
module sqe_heartbeat #(
    parameter int DELAY_CYC = 250,
    parameter int WIDTH_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic col_in,
    input  logic full_duplex,
    input  logic repeater_mode,
    input  logic inh_we,
    input  logic inh_wdata,
    output logic inh_rdata,
    output logic col_out
);
    logic fall;
    logic inh;
    logic allow;
    logic pulse;

    sqe_fall_det u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en_i (tx_en),
        .fall_o  (fall)
    );

    sqe_inhibit_reg u_inh (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (inh_we),
        .wdata_i (inh_wdata),
        .inh_o   (inh)
    );

    sqe_pulse_seq #(
        .DELAY_CYC (DELAY_CYC),
        .WIDTH_CYC (WIDTH_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall),
        .tx_en_i (tx_en),
        .allow_i (allow),
        .pulse_o (pulse)
    );

    always_comb begin
        allow     = !inh && !full_duplex && !repeater_mode;
        col_out   = col_in || (pulse && allow);
        inh_rdata = inh;
    end

    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        inh_rdata |-> (col_out == col_in)); // R4
    AST_FDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |-> (col_out == col_in)); // R5
    AST_RPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        repeater_mode |-> (col_out == col_in)); // R6
    AST_REAL_COL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        col_in |-> col_out); // R9
endmodule

// File: tb/tb_sqe_heartbeat.sv
`timescale 1ns/1ps
module tb_sqe_heartbeat;
    localparam int D = 12;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, col_in = 1'b0, full_duplex = 1'b0, repeater_mode = 1'b0;
    logic inh_we = 1'b0, inh_wdata = 1'b0;
    logic inh_rdata, col_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sqe_heartbeat #(.DELAY_CYC(D), .WIDTH_CYC(W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .col_in(col_in),
        .full_duplex(full_duplex), .repeater_mode(repeater_mode),
        .inh_we(inh_we), .inh_wdata(inh_wdata),
        .inh_rdata(inh_rdata), .col_out(col_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: consecutive low cycles since an enabled fall
    int  m_low = 0;
    bit  m_armed = 0;
    bit  m_prev = 0;
    bit  m_inh = 0;

    always @(posedge clk) begin
        bit en;
        bit exp_col;
        if (!rst_n) begin
            m_low = 0; m_armed = 0; m_prev = 0; m_inh = 0;
        end else begin
            en = !m_inh && !full_duplex && !repeater_mode;
            if (tx_en) begin
                m_low = 0; m_armed = 0;
            end else if (m_prev) begin
                m_low = 1; m_armed = en;
            end else begin
                if (m_low < 1000000) m_low++;
                if (!en) m_armed = 0;
            end
            m_prev = tx_en;
            if (inh_we) m_inh = inh_wdata;
        end
        #1;
        en = !m_inh && !full_duplex && !repeater_mode;
        exp_col = col_in || (m_armed && m_low >= D + 1 && m_low <= D + W && en);
        if (!finished) begin
            chk(col_out == exp_col, "R9 model col_out", col_out, exp_col);
            chk(inh_rdata == m_inh, "R7 model inh_rdata", inh_rdata, m_inh);
        end
    end

    task automatic write_inh(input bit v);
        @(negedge clk); inh_we = 1'b1; inh_wdata = v;
        @(negedge clk); inh_we = 1'b0;
    endtask

    // ends with tx_en falling on a negedge; returns pulse stats of following window
    task automatic frame(output int first, output int count);
        first = -1; count = 0;
        @(negedge clk); tx_en = 1'b1;
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        for (int i = 0; i < D + W + 4; i++) begin
            @(posedge clk); #1;
            if (col_out && !col_in) begin
                if (first < 0) first = i;
                count++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int f, c;
        repeat (3) @(posedge clk);
        #1;
        chk(col_out == 1'b0, "R1 reset col_out", col_out, 0);
        chk(inh_rdata == 1'b0, "R1 reset inh_rdata", inh_rdata, 0);
        @(negedge clk); col_in = 1'b1;
        @(posedge clk); #1;
        chk(col_out == 1'b1, "R1 col passes in reset", col_out, 1);
        @(negedge clk); col_in = 1'b0; rst_n = 1'b1;
        @(posedge clk); #1;
        chk(inh_rdata == 1'b0, "R1 inh after reset", inh_rdata, 0);

        // R10: tx_en low since reset, no pulse
        c = 0;
        for (int i = 0; i < D + W + 4; i++) begin
            @(posedge clk); #1; if (col_out) c++;
        end
        chk(c == 0, "R10 no fall low", c, 0);

        // R2 R3 normal heartbeat
        frame(f, c);
        chk(f == D, "R2 pulse start", f, D);
        chk(c == W, "R3 pulse width", c, W);
        frame(f, c);
        chk(f == D && c == W, "R2 R3 second frame", c, W);

        // R10: tx_en held high, no pulse
        @(negedge clk); tx_en = 1'b1;
        c = 0;
        for (int i = 0; i < D + W + 4; i++) begin
            @(posedge clk); #1; if (col_out) c++;
        end
        chk(c == 0, "R10 no fall high", c, 0);
        @(negedge clk); tx_en = 1'b0;
        repeat (D + W + 4) @(negedge clk);

        // R4 inhibit
        write_inh(1'b1);
        @(posedge clk); #1;
        chk(inh_rdata == 1'b1, "R7 readback 1", inh_rdata, 1);
        frame(f, c);
        chk(c == 0, "R4 inhibit blocks pulse", c, 0);
        write_inh(1'b0);
        @(posedge clk); #1;
        chk(inh_rdata == 1'b0, "R7 readback 0", inh_rdata, 0);

        // R5 full duplex, inhibit bit untouched
        @(negedge clk); full_duplex = 1'b1;
        frame(f, c);
        chk(c == 0, "R5 full duplex blocks pulse", c, 0);
        chk(inh_rdata == 1'b0, "R7 fdx leaves bit 0", inh_rdata, 0);
        write_inh(1'b1);
        @(posedge clk); #1;
        chk(inh_rdata == 1'b1, "R7 fdx readback 1", inh_rdata, 1);
        write_inh(1'b0);
        @(negedge clk); full_duplex = 1'b0;

        // R6 repeater
        @(negedge clk); repeater_mode = 1'b1;
        frame(f, c);
        chk(c == 0, "R6 repeater blocks pulse", c, 0);
        chk(inh_rdata == 1'b0, "R7 rpt leaves bit 0", inh_rdata, 0);
        @(negedge clk); repeater_mode = 1'b0;
        repeat (4) @(negedge clk);

        // R8 abort during active pulse
        @(negedge clk); tx_en = 1'b1;
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        repeat (D + 2) @(posedge clk);
        #1;
        chk(col_out == 1'b1, "R8 pulse active before abort", col_out, 1);
        @(negedge clk); tx_en = 1'b1;
        @(posedge clk); #1;
        chk(col_out == 1'b0, "R8 abort in pulse", col_out, 0);
        repeat (2) @(negedge clk);
        tx_en = 1'b0;
        // new fall restarts; abort during wait
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        c = 0;
        for (int i = 0; i < D + W + 4; i++) begin
            @(posedge clk); #1; if (col_out) c++;
        end
        chk(c == 0, "R8 abort in wait", c, 0);
        @(negedge clk); tx_en = 1'b0;
        repeat (D + W + 4) @(negedge clk);

        // R9 real collision merged
        @(negedge clk); col_in = 1'b1;
        @(posedge clk); #1;
        chk(col_out == 1'b1, "R9 col_in idle", col_out, 1);
        @(negedge clk); col_in = 1'b0;
        @(negedge clk); tx_en = 1'b1;
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        repeat (D + 1) @(negedge clk);
        col_in = 1'b1;
        @(posedge clk); #1;
        chk(col_out == 1'b1, "R9 col_in during pulse", col_out, 1);
        @(negedge clk); col_in = 1'b0;
        @(posedge clk); #1;
        chk(col_out == 1'b1, "R9 pulse continues", col_out, 1);
        repeat (W + 4) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule